// File: doc/BRIEF.md
# Private peripheral region access decoder

The decoder sits between a single requester and the internal register banks of a processor's 1 MiB private peripheral window (0xE000_0000 to 0xE00F_FFFF). Each request carries an address, a write flag, write data and a privilege bit. The decoder sends it to whichever implemented sub-region claims the address: the system control space, or that space's non-secure alias. Both views reach one shared stub register bank.

Any address inside the window that no sub-region claims falls to a catch-all handler with the lowest priority. That handler gives read-as-zero/write-ignored to privileged requesters and a bus error to unprivileged ones. An address outside the window is refused with a separate out-of-range flag.

Control is a two-state machine:

- `ST_IDLE` drives `req_ready` high. On an accepted request it takes the transition *accept* to `ST_RESP`.
- `ST_RESP` presents the registered response for exactly one cycle. It then takes the transition *retire* back to `ST_IDLE`.

Top module: `ppr_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1 and `rsp_valid` is 0. All stub registers read as zero.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the cycle that follows, and `req_ready` is 0 in that cycle.
- R3: An address whose upper 12 bits are not 0xE00 gives `rsp_oor`=1, `rsp_err`=0 and `rsp_rdata`=0. A write to such an address changes no register.
- R4: A privileged read of an unclaimed address inside the window returns `rsp_rdata`=0 with `rsp_err`=0 and `rsp_oor`=0.
- R5: A privileged write to an unclaimed address inside the window completes with `rsp_err`=0. It alters no state that a later read can observe.
- R6: Any unprivileged access to an unclaimed address inside the window returns `rsp_err`=1 with `rsp_rdata`=0.
- R7: The system control space (0xE000_E000 to 0xE000_EFFF) has four implemented 32-bit registers at byte offsets 0x0, 0x4, 0x8 and 0xC. Address bits [1:0] are ignored. These registers are readable and writable at either privilege level, and every write response carries `rsp_rdata`=0.
- R8: Inside the system control space, offsets 0x010 to 0xFFF are unimplemented. They follow the catch-all rule: zero or ignored when privileged, error when unprivileged.
- R9: The alias at 0xE002_E000 to 0xE002_EFFF reaches the same four registers as the system control space. A write through one view is seen through the other.
- R10: An address claimed by a sub-region is never handled by the catch-all, whatever the privilege level. Addresses one word below or above each sub-region are handled by the catch-all.
- R11: With `req_valid` held high, requests are accepted only every second cycle. Each accepted request yields exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged requester |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Bus error from an unprivileged unclaimed access |
| rsp_oor | output | 1 | Address lies outside the window |

## Verification
A new request can be presented in the same cycle that the previous response is on the port. Acceptance and response must then not overlap. The bench provokes this by holding `req_valid` high across several cycles, and also by issuing back-to-back writes and reads through both views of the register bank. A behavioural reference model predicts `req_ready`, `rsp_valid` and every response field on each clock. Any divergence is reported against the requirement under test.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
    localparam int ADDR_W = 32;
    localparam logic [ADDR_W-1:0] WIN_BASE = 32'hE000_0000;
    localparam int WIN_AW  = 20;   // 1 MiB window
    localparam int SUB_AW  = 12;   // 4 KiB sub-regions
    localparam int NUM_SUB = 2;

    // Sub-region bases, relative to the window base; index order is priority.
    function automatic logic [WIN_AW-1:0] sub_base(input int idx);
        case (idx)
            0:       return 20'h0E000;
            default: return 20'h2E000;
        endcase
    endfunction

    typedef enum logic [1:0] {
        RGN_SCS,
        RGN_SCS_ALIAS,
        RGN_DEFAULT,
        RGN_OUTSIDE
    } rgn_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } st_e;
endpackage

// File: rtl/ppr_region_map.sv
module ppr_region_map
    import ppr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [SUB_AW-1:0] sub_off
);
    logic [ADDR_W-1:0]  rel;
    logic [WIN_AW-1:0]  win_off;
    logic               in_win;
    logic [NUM_SUB-1:0] hit;

    // Offset computed relative to the window base before any decode.
    assign rel     = addr - WIN_BASE;
    assign in_win  = (rel[ADDR_W-1:WIN_AW] == '0);
    assign win_off = rel[WIN_AW-1:0];
    assign sub_off = win_off[SUB_AW-1:0];

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_hit
        localparam logic [WIN_AW-1:0] BASE = sub_base(g);
        assign hit[g] = in_win &&
                        (win_off[WIN_AW-1:SUB_AW] == BASE[WIN_AW-1:SUB_AW]);
    end

    // Implemented sub-regions first; the catch-all only when none claims.
    always_comb begin
        if (!in_win)
            rgn = RGN_OUTSIDE;
        else if (hit[0])
            rgn = RGN_SCS;
        else if (hit[1])
            rgn = RGN_SCS_ALIAS;
        else
            rgn = RGN_DEFAULT;
    end
endmodule

// File: rtl/ppr_scs_stub.sv
module ppr_scs_stub
    import ppr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SUB_AW-1:0] off,
    input  logic [DW-1:0]     wdata,
    output logic              impl,
    output logic [DW-1:0]     rdata
);
    localparam int IDX_W = SUB_AW - 2;
    localparam logic [IDX_W-1:0] NREG_L = IDX_W'(NREG);

    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    regs [NREG];

    assign idx  = off[SUB_AW-1:2];
    assign impl = (idx < NREG_L);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (idx == IDX_W'(i)))
                regs[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i))
                rdata = regs[i];
        end
    end
endmodule

// File: rtl/ppr_decoder.sv
module ppr_decoder
    import ppr_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_oor
);
    rgn_e              rgn;
    logic [SUB_AW-1:0] sub_off;
    logic              accept;
    logic              in_scs;
    logic              stub_impl;
    logic [DW-1:0]     stub_rdata;

    st_e               st_q, st_d;

    logic              nx_err, nx_oor;
    logic [DW-1:0]     nx_data;
    logic              q_err, q_oor;
    logic [DW-1:0]     q_data;

    ppr_region_map u_map (
        .addr    (req_addr),
        .rgn     (rgn),
        .sub_off (sub_off)
    );

    assign accept = req_valid && req_ready;
    assign in_scs = (rgn == RGN_SCS) || (rgn == RGN_SCS_ALIAS);

    ppr_scs_stub #(.NREG(NREG), .DW(DW)) u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept && req_write && in_scs),
        .off   (sub_off),
        .wdata (req_wdata),
        .impl  (stub_impl),
        .rdata (stub_rdata)
    );

    // Response content for the request on the port.
    always_comb begin
        nx_err  = 1'b0;
        nx_oor  = 1'b0;
        nx_data = '0;
        unique case (rgn)
            RGN_OUTSIDE: nx_oor = 1'b1;
            RGN_SCS, RGN_SCS_ALIAS: begin
                if (stub_impl)
                    nx_data = req_write ? '0 : stub_rdata;
                else
                    nx_err = !req_priv;
            end
            RGN_DEFAULT: nx_err = !req_priv;
        endcase
    end

    // Next-state logic: accept and retire transitions.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Response capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_err  <= 1'b0;
            q_oor  <= 1'b0;
            q_data <= '0;
        end else if (accept) begin
            q_err  <= nx_err;
            q_oor  <= nx_oor;
            q_data <= nx_data;
        end
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_oor   = 1'b0;
        rsp_rdata = '0;
        unique case (st_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_err   = q_err;
                rsp_oor   = q_oor;
                rsp_rdata = q_data;
            end
        endcase
    end
endmodule

// File: rtl/ppr_decoder_chk.sv
module ppr_decoder_chk
    import ppr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_priv,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        rsp_oor,
    input rgn_e        rgn
);
    a_r2_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r2_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r11_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r3_outside_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr[31:20] != 12'hE00)) |=> (rsp_oor && !rsp_err));

    a_r3_oor_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> (rsp_rdata == 32'h0));

    a_r6_unpriv_default_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_priv && (rgn == RGN_DEFAULT)) |=> rsp_err);

    a_r4_priv_default_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_priv && (rgn == RGN_DEFAULT)) |=>
            (!rsp_err && rsp_rdata == 32'h0));
endmodule

bind ppr_decoder ppr_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_priv  (req_priv),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .rsp_oor   (rsp_oor),
    .rgn       (rgn)
);

// File: tb/ppr_decoder_test.sv
module ppr_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_priv = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        rsp_oor;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    ppr_decoder uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_oor(rsp_oor)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0] m_regs [4];
    bit          m_busy;
    bit          m_oor, m_err;
    logic [31:0] m_data;

    // index of implemented register, or -1; -2 outside window; -3 catch-all
    function automatic int classify(input logic [31:0] a);
        int off;
        if (a < 32'hE000_0000 || a > 32'hE00F_FFFF) return -2;
        off = int'(a - 32'hE000_0000);
        if ((off >= 'hE000 && off <= 'hEFFF) || (off >= 'h2E000 && off <= 'h2EFFF)) begin
            if ((off & 'hFFF) < 'h10) return (off & 'hF) >> 2;
            return -3;
        end
        return -3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            for (int i = 0; i < 4; i++) m_regs[i] <= '0;
        end else if (m_busy) begin
            m_busy <= 1'b0;
        end else if (req_valid) begin
            int c;
            c = classify(req_addr);
            m_busy <= 1'b1;
            m_oor  <= (c == -2);
            m_err  <= (c == -3) && !req_priv;
            m_data <= (c >= 0 && !req_write) ? m_regs[c] : 32'h0;
            if (c >= 0 && req_write) m_regs[c] <= req_wdata;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_ready == !m_busy, "R2", "req_ready", {31'b0, req_ready}, {31'b0, !m_busy});
            chk(rsp_valid == m_busy, "R2", "rsp_valid", {31'b0, rsp_valid}, {31'b0, m_busy});
            if (m_busy) begin
                chk(rsp_oor == m_oor, cur_req, "rsp_oor", {31'b0, rsp_oor}, {31'b0, m_oor});
                chk(rsp_err == m_err, cur_req, "rsp_err", {31'b0, rsp_err}, {31'b0, m_err});
                chk(rsp_rdata == m_data, cur_req, "rsp_rdata", rsp_rdata, m_data);
            end
        end
    end

    task automatic issue(input logic [31:0] a, input bit w, input logic [31:0] d,
                         input bit p, input string rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_req   = rq;
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        req_priv  = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1", "valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
        issue(32'hE000_E004, 0, 0, 1, "R1");

        // R7: implemented registers, both privilege levels, low bits ignored
        issue(32'hE000_E000, 1, 32'h1111_0000, 1, "R7");
        issue(32'hE000_E004, 1, 32'h2222_0001, 0, "R7");
        issue(32'hE000_E00B, 1, 32'h3333_0002, 1, "R7");
        issue(32'hE000_E00C, 1, 32'h4444_0003, 0, "R7");
        issue(32'hE000_E000, 0, 0, 0, "R7");
        issue(32'hE000_E005, 0, 0, 1, "R7");
        issue(32'hE000_E008, 0, 0, 0, "R7");
        issue(32'hE000_E00E, 0, 0, 1, "R7");

        // R9: alias reaches the same registers
        issue(32'hE002_E008, 1, 32'hA5A5_5A5A, 1, "R9");
        issue(32'hE000_E008, 0, 0, 1, "R9");
        issue(32'hE000_E000, 1, 32'hC0DE_0001, 0, "R9");
        issue(32'hE002_E000, 0, 0, 0, "R9");

        // R8: unimplemented offsets in the control space
        issue(32'hE000_E010, 0, 0, 1, "R8");
        issue(32'hE000_E010, 0, 0, 0, "R8");
        issue(32'hE002_EFFC, 1, 32'hFFFF_FFFF, 1, "R8");
        issue(32'hE000_EFFC, 1, 32'h1234_5678, 0, "R8");
        issue(32'hE000_E000, 0, 0, 1, "R8");

        // R4: privileged reads of the catch-all
        issue(32'hE000_0000, 0, 0, 1, "R4");
        issue(32'hE00F_FFFC, 0, 0, 1, "R4");
        issue(32'hE000_1234, 0, 0, 1, "R4");

        // R5: privileged writes to the catch-all are discarded
        issue(32'hE000_0000, 1, 32'hDEAD_BEEF, 1, "R5");
        issue(32'hE000_0000, 0, 0, 1, "R5");
        issue(32'hE001_E004, 1, 32'hDEAD_BEEF, 1, "R5");
        issue(32'hE000_E004, 0, 0, 1, "R5");

        // R6: unprivileged catch-all errors
        issue(32'hE004_0000, 0, 0, 0, "R6");
        issue(32'hE004_0000, 1, 32'h5555_5555, 0, "R6");
        issue(32'hE00F_FFFC, 0, 0, 0, "R6");

        // R3: outside the window
        issue(32'hDFFF_FFFC, 0, 0, 1, "R3");
        issue(32'hE010_0000, 0, 0, 0, "R3");
        issue(32'h0000_E000, 0, 0, 1, "R3");
        issue(32'hE010_E000, 1, 32'h0BAD_0BAD, 1, "R3");
        issue(32'hF000_E00C, 1, 32'h0BAD_0BAD, 0, "R3");
        issue(32'hE000_E000, 0, 0, 1, "R3");
        issue(32'hE000_E00C, 0, 0, 1, "R3");

        // R10: priority and sub-region boundaries
        issue(32'hE000_E000, 0, 0, 0, "R10");
        issue(32'hE002_E004, 0, 0, 0, "R10");
        issue(32'hE000_DFFC, 0, 0, 0, "R10");
        issue(32'hE000_F000, 0, 0, 0, "R10");
        issue(32'hE002_DFFC, 0, 0, 0, "R10");
        issue(32'hE002_F000, 0, 0, 0, "R10");
        issue(32'hE001_E000, 0, 0, 1, "R10");

        // R11: request held high across responses
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_req   = "R11";
        req_valid = 1'b1;
        req_write = 1'b0;
        req_priv  = 1'b1;
        req_addr  = 32'hE000_E008;
        repeat (4) @(negedge clk);
        req_addr  = 32'hE004_0000;
        req_priv  = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule